// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address. It reads one 64-bit entry from each of up to four levels of in-memory translation tables. The walk starts at a root table, whose 4KiB frame number is a plain input, and every entry it reads names the frame of the next table. Each entry is checked against the kind of access and the privilege of the requester. The walk ends with one of three results: a 4KiB page translation, a 1GiB page translation taken at the second level, or a page fault that gives a cause code and the level where the fault was found.

Requests arrive on a valid/ready port and carry the virtual address, an access kind and a user flag. The block handles one walk at a time. It holds `req_ready` low from the moment it accepts a request until its result has been taken. Table reads go out on a valid/ready request port. Read data comes back on a valid/ready response port, and the block raises `mem_rsp_ready` only while a read is outstanding. Results leave on a valid/ready port. Both the result and the outgoing read request hold steady for as long as the far side applies back-pressure. The root frame and the 1GiB enable are plain control pins, sampled when a request is accepted and while the walk runs.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only when no walk is in flight. After a request is accepted, no other request is accepted until the result handshake completes, and the block never asks for a table read while a result or a read response is pending.
- R2: The top-level table read is at byte address {root_frame, va[47:39], 3'b000}. Each later read is at {entry[51:12] of the previous level, index, 3'b000}, where the index is va[38:30], va[29:21] or va[20:12] for levels 2, 1 and 0. Levels are numbered 3 (top) down to 0.
- R3: A walk that passes all four levels returns fault=0, cause=0, level=0 and paddr = {entry[51:12], va[11:0]} from the level 0 entry.
- R4: When huge_en=1 and a level 2 entry that passes its checks has bit 7 set, the walk ends after two reads with level=2 and paddr = {entry[51:30], va[29:0]}. When huge_en=0 that bit is ignored and the walk goes on to level 1.
- R5: An entry whose bit 0 (present) is clear ends the walk with fault=1, cause=1, paddr=0 and the level of that entry. No further table read is issued.
- R6: An entry with any of bits 62:52 set faults with cause=4.
- R7: A write (kind=1) faults with cause=2 if bit 1 of the entry is clear. Other kinds ignore that bit.
- R8: A request with user=1 faults with cause=3 if bit 2 of the entry is clear. Requests with user=0 ignore that bit.
- R9: An instruction fetch (kind=2) faults with cause=5 if bit 63 of the entry is set. Reads (kind=0) and writes ignore that bit.
- R10: When one entry breaks several rules, the cause reported is the first in this order: not-present (1), reserved (4), write (2), privilege (3), no-execute (5).
- R11: While `rsp_valid` is high and `rsp_ready` is low, the result fields stay unchanged. While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_frame | input | 40 | Frame number (address bits 51:12) of the top-level table |
| huge_en | input | 1 | Allows 1GiB pages at level 2 |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 48 | Virtual address to translate |
| req_kind | input | 2 | 0 read, 1 write, 2 instruction fetch |
| req_user | input | 1 | 1 for a non-ring-0 requester |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block waits for read data |
| mem_rsp_data | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | 1 when the walk faulted |
| rsp_cause | output | 3 | 0 none, 1 not present, 2 write, 3 privilege, 4 reserved, 5 no-execute |
| rsp_level | output | 2 | Level at which the walk ended or faulted |
| rsp_paddr | output | 52 | Translated physical address, 0 on a fault |

## Verification
The assertions assume that the memory side returns exactly one response for each accepted read, and never one while no read is outstanding. They also assume that the consumer and the memory may stall for any number of cycles. The bench memory keeps to this: it answers only after a read handshake, holds its data until `mem_rsp_ready` takes it, and applies random stalls on both the read request and the result. Root frame and huge_en change only between walks. The reference model walks the same sparse memory to predict every read address and every result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ENTRY_W  = 64;
  localparam int IDX_W    = 9;
  localparam int OFF_W    = 12;

  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_HUGE    = 7;
  localparam int BIT_NOEXEC  = 63;

  localparam logic [1:0] KIND_READ  = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_ABSENT   = 3'd1,
    CAUSE_WRITE    = 3'd2,
    CAUSE_PRIV     = 3'd3,
    CAUSE_RESERVED = 3'd4,
    CAUSE_NOEXEC   = 3'd5
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int PA_W   = 52,
  parameter int LEVELS = 4,
  localparam int OFF_W = ptw_pkg::OFF_W,
  localparam int IDX_W = ptw_pkg::IDX_W,
  localparam int VA_W  = OFF_W + LEVELS * IDX_W,
  localparam int LVL_W = $clog2(LEVELS),
  localparam int FR_W  = PA_W - OFF_W
) (
  input  logic [FR_W-1:0]  table_frame,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  entry_addr
);
  logic [IDX_W-1:0] idx_by_level [LEVELS];

  // One index slice per level, lowest level nearest the page offset
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_by_level[g] = vaddr[OFF_W + IDX_W*g +: IDX_W];
  end

  assign entry_addr = {table_frame, idx_by_level[level], {(OFF_W-IDX_W){1'b0}}};

  logic unused_page_offset;
  assign unused_page_offset = ^vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check #(
  parameter int PA_W = 52,
  localparam int ENTRY_W = ptw_pkg::ENTRY_W
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [1:0]         kind,
  input  logic               user,
  output logic               fault,
  output ptw_pkg::cause_e    cause
);
  import ptw_pkg::*;

  logic rsvd_hit;
  assign rsvd_hit = |entry[ENTRY_W-2:PA_W];

  // Ordered rules: absent entry first, then malformed entry, then rights
  always_comb begin
    cause = CAUSE_NONE;
    if (!entry[BIT_PRESENT])
      cause = CAUSE_ABSENT;
    else if (rsvd_hit)
      cause = CAUSE_RESERVED;
    else if (kind == KIND_WRITE && !entry[BIT_WRITE])
      cause = CAUSE_WRITE;
    else if (user && !entry[BIT_USER])
      cause = CAUSE_PRIV;
    else if (kind == KIND_FETCH && entry[BIT_NOEXEC])
      cause = CAUSE_NOEXEC;
  end

  assign fault = (cause != CAUSE_NONE);

  logic unused_entry_bits;
  assign unused_entry_bits = ^{entry[PA_W-1:BIT_HUGE], entry[BIT_HUGE-1:BIT_USER+1]};
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W       = 52,
  parameter int LEVELS     = 4,
  parameter int HUGE_LEVEL = 2,
  localparam int OFF_W   = ptw_pkg::OFF_W,
  localparam int IDX_W   = ptw_pkg::IDX_W,
  localparam int ENTRY_W = ptw_pkg::ENTRY_W,
  localparam int VA_W    = OFF_W + LEVELS * IDX_W,
  localparam int LVL_W   = $clog2(LEVELS),
  localparam int FR_W    = PA_W - OFF_W,
  localparam int HUGE_SH = OFF_W + HUGE_LEVEL * IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FR_W-1:0]    root_frame,
  input  logic               huge_en,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [1:0]         req_kind,
  input  logic               req_user,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_fault,
  output logic [2:0]         rsp_cause,
  output logic [LVL_W-1:0]   rsp_level,
  output logic [PA_W-1:0]    rsp_paddr
);
  import ptw_pkg::*;

  localparam logic [LVL_W-1:0] TOP_LVL  = LVL_W'(LEVELS - 1);
  localparam logic [LVL_W-1:0] HUGE_LVL = LVL_W'(HUGE_LEVEL);

  walk_state_e      state_q;
  logic [LVL_W-1:0] lvl_q;
  logic [FR_W-1:0]  frame_q;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       kind_q;
  logic             user_q;
  logic             fault_q;
  cause_e           cause_q;
  logic [LVL_W-1:0] res_lvl_q;
  logic [PA_W-1:0]  paddr_q;

  logic   chk_fault;
  cause_e chk_cause;
  logic   huge_stop;

  ptw_entry_addr #(.PA_W(PA_W), .LEVELS(LEVELS)) u_addr (
    .table_frame (frame_q),
    .vaddr       (va_q),
    .level       (lvl_q),
    .entry_addr  (mem_req_addr)
  );

  ptw_entry_check #(.PA_W(PA_W)) u_check (
    .entry (mem_rsp_data),
    .kind  (kind_q),
    .user  (user_q),
    .fault (chk_fault),
    .cause (chk_cause)
  );

  assign huge_stop = huge_en && (lvl_q == HUGE_LVL) && mem_rsp_data[BIT_HUGE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      lvl_q     <= '0;
      frame_q   <= '0;
      va_q      <= '0;
      kind_q    <= KIND_READ;
      user_q    <= 1'b0;
      fault_q   <= 1'b0;
      cause_q   <= CAUSE_NONE;
      res_lvl_q <= '0;
      paddr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          kind_q  <= req_kind;
          user_q  <= req_user;
          frame_q <= root_frame;
          lvl_q   <= TOP_LVL;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          res_lvl_q <= lvl_q;
          if (chk_fault) begin
            fault_q <= 1'b1;
            cause_q <= chk_cause;
            paddr_q <= '0;
            state_q <= ST_DONE;
          end else if (huge_stop) begin
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
            paddr_q <= {mem_rsp_data[PA_W-1:HUGE_SH], va_q[HUGE_SH-1:0]};
            state_q <= ST_DONE;
          end else if (lvl_q == '0) begin
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
            paddr_q <= {mem_rsp_data[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
            state_q <= ST_DONE;
          end else begin
            frame_q <= mem_rsp_data[PA_W-1:OFF_W];
            lvl_q   <= lvl_q - 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_DONE: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_rsp_ready = (state_q == ST_WAIT);
  assign rsp_valid     = (state_q == ST_DONE);
  assign rsp_fault     = fault_q;
  assign rsp_cause     = cause_q;
  assign rsp_level     = res_lvl_q;
  assign rsp_paddr     = paddr_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W   = 52,
  parameter int LEVELS = 4,
  localparam int VA_W  = ptw_pkg::OFF_W + LEVELS * ptw_pkg::IDX_W,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_rsp_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_fault,
  input logic [2:0]       rsp_cause,
  input logic [LVL_W-1:0] rsp_level,
  input logic [PA_W-1:0]  rsp_paddr
);
  a_r1_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_req_valid && !mem_rsp_ready));

  a_r1_no_second_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r2_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  a_r3_clean_result: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_cause == 3'd0));

  a_r5_fault_result: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_cause inside {[3'd1:3'd5]} && rsp_paddr == '0));

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_fault) && $stable(rsp_cause) &&
       $stable(rsp_level) && $stable(rsp_paddr)));

  a_r11_mem_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  logic unused_va;
  assign unused_va = ^req_vaddr;
endmodule

bind pt_walker ptw_walker_chk #(.PA_W(PA_W), .LEVELS(LEVELS)) u_chk (.*);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [39:0] root_frame = 40'h1;
  logic        huge_en = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [47:0] req_vaddr = '0;
  logic [1:0]  req_kind = 2'd0;
  logic        req_user = 1'b0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_fault;
  logic [2:0]  rsp_cause;
  logic [1:0]  rsp_level;
  logic [51:0] rsp_paddr;

  pt_walker u_dut (.*);

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [63:0] mem [logic [51:0]];
  logic [51:0] exp_q [$];

  localparam logic [63:0] F_P   = 64'h1;
  localparam logic [63:0] F_RW  = 64'h2;
  localparam logic [63:0] F_US  = 64'h4;
  localparam logic [63:0] F_PS  = 64'h80;
  localparam logic [63:0] F_NX  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] F_RSV = 64'h0010_0000_0000_0000;
  localparam logic [63:0] F_ALL = 64'h7;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [63:0] ent(input logic [39:0] fr, input logic [63:0] fl);
    return {12'h0, fr, 12'h0} | fl;
  endfunction

  task automatic chain(input logic [47:0] va, input logic [63:0] f3, f2, f1, f0);
    mem[{40'h1, va[47:39], 3'b0}] = ent(40'h2, f3);
    mem[{40'h2, va[38:30], 3'b0}] = ent(40'h3, f2);
    mem[{40'h3, va[29:21], 3'b0}] = ent(40'h4, f1);
    mem[{40'h4, va[20:12], 3'b0}] = ent(40'hABCDE, f0);
  endtask

  // Behavioural reference walk: predicts read addresses and the result
  task automatic ref_walk(input logic [47:0] va, input logic [1:0] kind, input bit user,
                          output logic [57:0] res);
    logic [39:0] fr;
    logic [51:0] a;
    logic [63:0] e;
    logic [2:0]  c;
    fr = root_frame;
    res = '0;
    for (int l = 3; l >= 0; l--) begin
      a = {fr, va[12+9*l +: 9], 3'b0};
      exp_q.push_back(a);
      e = rd(a);
      c = 3'd0;
      if (!e[0]) c = 3'd1;
      else if (|e[62:52]) c = 3'd4;
      else if (kind == 2'd1 && !e[1]) c = 3'd2;
      else if (user && !e[2]) c = 3'd3;
      else if (kind == 2'd2 && e[63]) c = 3'd5;
      if (c != 3'd0) begin
        res = {1'b1, c, 2'(l), 52'h0};
        return;
      end
      if (l == 2 && e[7] && huge_en) begin
        res = {1'b0, 3'd0, 2'd2, e[51:30], va[29:0]};
        return;
      end
      if (l == 0) res = {1'b0, 3'd0, 2'd0, e[51:12], va[11:0]};
      fr = e[51:12];
    end
  endtask

  // Memory model with random stalls on both the read request and the response
  initial begin
    forever begin
      @(negedge clk);
      mem_req_ready = ($urandom % 3) != 0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        logic [51:0] a;
        a = mem_req_addr;
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected table read", 64'(a), 64'h0);
        else begin
          logic [51:0] e;
          e = exp_q.pop_front();
          chk(a == e, "R2 table read address", 64'(a), 64'(e));
        end
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(a);
        while (!mem_rsp_ready) @(negedge clk);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic run(input logic [47:0] va, input logic [1:0] kind, input bit user, input string tag);
    logic [57:0] exp_res, snap;
    bit held;
    ref_walk(va, kind, user, exp_res);
    @(negedge clk);
    req_vaddr = va; req_kind = kind; req_user = user; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    held = 1'b0;
    snap = '0;
    forever begin
      chk(!req_ready, "R1 busy during walk", 64'(req_ready), 64'h0);
      if (rsp_valid) begin
        if (held)
          chk({rsp_fault, rsp_cause, rsp_level, rsp_paddr} == snap, "R11 result held",
              64'({rsp_fault, rsp_cause, rsp_level, rsp_paddr}), 64'(snap));
        rsp_ready = ($urandom % 2) != 0;
        if (rsp_ready) begin
          chk({rsp_fault, rsp_cause, rsp_level, rsp_paddr} == exp_res, tag,
              64'({rsp_fault, rsp_cause, rsp_level, rsp_paddr}), 64'(exp_res));
          @(negedge clk);
          rsp_ready = 1'b0;
          break;
        end
        snap = {rsp_fault, rsp_cause, rsp_level, rsp_paddr};
        held = 1'b1;
      end
      @(negedge clk);
    end
    chk(exp_q.size() == 0, "R5 walk read count", 64'(exp_q.size()), 64'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(1'b0, "watchdog expired", 64'(cycles), 64'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [47:0] va;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid && !mem_rsp_ready, "R1 reset state",
        64'({req_ready, rsp_valid, mem_req_valid, mem_rsp_ready}), 64'h8);

    va = 48'h1234_5678_9ABC;
    chain(va, F_ALL, F_ALL, F_ALL, F_ALL);
    run(va, 2'd0, 1'b0, "R3 4K read");
    run(va, 2'd1, 1'b1, "R3 4K user write");
    va = 48'hFFFF_FFFF_FFFF;
    chain(va, F_ALL, F_ALL, F_ALL, F_ALL);
    run(va, 2'd2, 1'b1, "R3 4K fetch top index");

    va = 48'h0040_2030_0400;
    chain(va, F_ALL, F_ALL, F_RW | F_US, F_ALL);
    run(va, 2'd0, 1'b0, "R5 absent at level 1");
    chain(va, F_ALL, F_ALL, F_ALL, 64'h0);
    run(va, 2'd0, 1'b0, "R5 absent at level 0");

    chain(va, F_ALL | F_RSV, F_ALL, F_ALL, F_ALL);
    run(va, 2'd0, 1'b0, "R6 reserved at level 3");
    chain(va, F_ALL, F_ALL, F_ALL, F_ALL | 64'h4000_0000_0000_0000);
    run(va, 2'd0, 1'b0, "R6 reserved bit 62 at level 0");

    chain(va, F_ALL, F_P | F_US, F_ALL, F_ALL);
    run(va, 2'd1, 1'b0, "R7 write protect at level 2");
    run(va, 2'd0, 1'b1, "R7 read ignores write bit");

    chain(va, F_ALL, F_ALL, F_ALL, F_P | F_RW);
    run(va, 2'd0, 1'b1, "R8 user denied at level 0");
    run(va, 2'd1, 1'b0, "R8 supervisor ignores user bit");

    chain(va, F_ALL, F_ALL, F_ALL | F_NX, F_ALL);
    run(va, 2'd2, 1'b0, "R9 no-execute fetch at level 1");
    run(va, 2'd0, 1'b1, "R9 read ignores no-execute");

    chain(va, F_ALL | F_RSV, F_ALL, F_ALL, F_ALL);
    mem[{40'h1, va[47:39], 3'b0}] = ent(40'h2, F_RSV | F_US);
    run(va, 2'd1, 1'b0, "R10 absent before reserved");
    chain(va, F_P | F_RSV, F_ALL, F_ALL, F_ALL);
    run(va, 2'd1, 1'b1, "R10 reserved before write");
    chain(va, F_ALL, F_P | F_NX, F_ALL, F_ALL);
    run(va, 2'd2, 1'b1, "R10 privilege before no-execute");
    chain(va, F_ALL, F_P, F_ALL, F_ALL);
    run(va, 2'd1, 1'b1, "R10 write before privilege");

    va = 48'h00C1_5555_1234;
    chain(va, F_ALL, F_ALL, F_ALL, F_ALL);
    mem[{40'h2, va[38:30], 3'b0}] = ent(40'h1234_5003, F_ALL | F_PS);
    @(negedge clk); huge_en = 1'b1;
    run(va, 2'd0, 1'b1, "R4 1GiB page");
    @(negedge clk); huge_en = 1'b0;
    run(va, 2'd0, 1'b1, "R4 size bit ignored when disabled");

    for (int i = 0; i < 60; i++) begin
      logic [63:0] f [4];
      va = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      for (int k = 0; k < 4; k++) begin
        f[k] = (($urandom % 10) != 0) ? F_P : 64'h0;
        if ($urandom % 2) f[k] |= F_RW;
        if ($urandom % 2) f[k] |= F_US;
        if (($urandom % 4) == 0) f[k] |= F_NX;
        if (($urandom % 10) == 0) f[k] |= F_RSV;
      end
      if ($urandom % 2) f[2] |= F_PS;
      chain(va, f[0], f[1], f[2], f[3]);
      @(negedge clk);
      huge_en = $urandom % 2;
      root_frame = 40'h1;
      run(va, 2'($urandom % 3), $urandom % 2, "R10 random walk");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule